// File: doc/BRIEF.md
# Dual-Output Serial Flash Read Engine

This block is a host-side serial master that pulls a run of bytes out of a serial flash with the dual-output fast read command. A client pulses `start` with a 24-bit start address and a byte count. The engine lowers chip select and sends the command byte and the address on the shared line `io0`, one bit per clock. It then lets eight dummy clocks pass with `io0` released. After that it captures two bits per clock, one from `io1` and one from `io0`, until the requested number of bytes has arrived. The flash advances its own address, so one command covers the whole run.

Each completed byte is handed out on a valid/ready stream through a single output register. When that register still holds a byte the consumer has not taken, and the next clock would complete another byte, the serial clock is frozen low with chip select held. Nothing is dropped. The serial clock idles low; outgoing bits change on its falling edge and incoming bits are taken on its rising edge. Its half period is a parameter counted in system clock cycles.

The controller is a five-state machine:
- `ST_IDLE` goes to `ST_SEND` on a start with a non-zero count.
- `ST_SEND` (command and address) goes to `ST_DUMMY` on the falling edge after the 32nd rising edge.
- `ST_DUMMY` goes to `ST_DATA` on the falling edge after the 8th dummy rising edge.
- `ST_DATA` goes to `ST_TAIL` on the rising edge that completes the last byte.
- `ST_TAIL` goes back to `ST_IDLE` on the final falling edge.

Top module: `dual_read_engine`

## Requirements
- R1: After reset `cs_n` is 1, `sck` is 0, `busy` is 0, `done` is 0 and `m_valid` is 0.
- R2: A transfer first shifts the opcode 0x3B and then the 24-bit start address on `io0`, MSB first, one bit per `sck` period. Bits change only while `sck` falls, and `sck` is low whenever `cs_n` is high.
- R3: Exactly eight dummy `sck` periods follow the address. The first data bits are taken on the 41st rising edge of the transfer.
- R4: The engine stops driving `io0` at the falling edge after the last address bit. It keeps it released through the dummy, data and tail phases.
- R5: Each byte takes four `sck` periods. `io1` supplies bits 7, 5, 3, 1 and `io0` supplies bits 6, 4, 2, 0, with the higher pair sampled first. Bytes leave in ascending address order.
- R6: A byte on the stream keeps `m_valid` high and `m_data` stable until `m_ready`. If a further byte would complete while the register is full, `sck` stays low and `cs_n` stays asserted, so no byte is lost.
- R7: A transfer with count N yields exactly N bytes and exactly 40 + 4N rising `sck` edges. After the last edge one falling edge follows, then `cs_n` rises with a one-cycle `done` pulse and `busy` drops.
- R8: `start` while `busy` is high is ignored; the running transfer's command, address and length are unchanged.
- R9: A start with count 0 asserts no chip select and gives a `done` pulse in the following cycle.
- R10: While running and not paused, consecutive rising `sck` edges are 2·HALF system cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a read (taken only when idle) |
| start_addr | input | 24 | First flash byte address |
| start_len | input | LEN_W | Number of bytes to read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at transfer end |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| io0 | inout | 1 | Shared line: command/address out, data bits 6,4,2,0 in |
| io1 | input | 1 | Data bits 7,5,3,1 in |
| m_data | output | 8 | Stream byte |
| m_valid | output | 1 | Stream byte valid |
| m_ready | input | 1 | Stream consumer ready |

## Verification
The assertions assume a stream consumer that may drop or raise `m_ready` in any cycle. They also assume a flash that changes `io1` and `io0` only after a falling `sck` edge and drives `io0` only once the dummy phase has passed. The bench flash model obeys that timing exactly. It drives `io0` solely from the falling edge after the 40th rising edge, and it counts rising edges so that the header bits and clock totals can be compared with arithmetic expectations. The sweeps cover lengths one to five. They run against three ready patterns and against start addresses near zero, in the middle and at the 24-bit wrap, with one long stall and one start request sent mid-transfer.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;
    localparam logic [7:0] RD_OPCODE  = 8'h3B;
    localparam int         ADDR_BITS  = 24;
    localparam int         HDR_BITS   = 8 + ADDR_BITS;
    localparam int         DUMMY_CLKS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_DUMMY,
        ST_DATA,
        ST_TAIL
    } rd_state_e;
endpackage

// File: rtl/sck_gen.sv
module sck_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hold,
    output logic sck,
    output logic rise,
    output logic fall
);
    localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [DIV_W-1:0] div_q;
    logic             tick;

    assign tick = run && !hold && (div_q == DIV_W'(HALF - 1));
    assign rise = tick && !sck;
    assign fall = tick && sck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            sck   <= 1'b0;
        end else if (!run) begin
            div_q <= '0;
            sck   <= 1'b0;
        end else if (!hold) begin
            if (tick) begin
                div_q <= '0;
                sck   <= ~sck;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rx_byte_buf.sv
module rx_byte_buf (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample,
    input  logic       last_pair,
    input  logic       bit_hi,
    input  logic       bit_lo,
    input  logic       m_ready,
    output logic [7:0] m_data,
    output logic       m_valid
);
    logic [5:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            m_data  <= '0;
            m_valid <= 1'b0;
        end else begin
            if (sample) begin
                acc_q <= {acc_q[3:0], bit_hi, bit_lo};
            end
            if (sample && last_pair) begin
                m_data  <= {acc_q, bit_hi, bit_lo};
                m_valid <= 1'b1;
            end else if (m_valid && m_ready) begin
                m_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dual_read_engine.sv
module dual_read_engine
    import spi_dual_pkg::*;
#(
    parameter int HALF  = 2,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [23:0]      start_addr,
    input  logic [LEN_W-1:0] start_len,
    output logic             busy,
    output logic             done,
    output logic             sck,
    output logic             cs_n,
    inout  wire              io0,
    input  logic             io1,
    output logic [7:0]       m_data,
    output logic             m_valid,
    input  logic             m_ready
);
    localparam int CNT_W = $clog2(HDR_BITS + 1);

    rd_state_e               state, state_nx;
    logic [HDR_BITS-1:0]     sr_q;
    logic [CNT_W-1:0]        cnt_q;
    logic [LEN_W-1:0]        remain_q;
    logic                    io_oe;
    logic                    rise, fall, hold;
    logic                    last_pair;

    assign io0       = io_oe ? sr_q[HDR_BITS-1] : 1'bz;
    assign busy      = (state != ST_IDLE);
    assign last_pair = (cnt_q[1:0] == 2'd3);
    assign hold      = (state == ST_DATA) && !sck && last_pair && m_valid && !m_ready;

    sck_gen #(.HALF(HALF)) u_sck (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .hold (hold),
        .sck  (sck),
        .rise (rise),
        .fall (fall)
    );

    rx_byte_buf u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (rise && (state == ST_DATA)),
        .last_pair(last_pair),
        .bit_hi   (io1),
        .bit_lo   (io0),
        .m_ready  (m_ready),
        .m_data   (m_data),
        .m_valid  (m_valid)
    );

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start && (start_len != '0)) state_nx = ST_SEND;
            ST_SEND:  if (fall && (cnt_q == CNT_W'(HDR_BITS))) state_nx = ST_DUMMY;
            ST_DUMMY: if (fall && (cnt_q == CNT_W'(DUMMY_CLKS))) state_nx = ST_DATA;
            ST_DATA:  if (rise && last_pair && (remain_q == LEN_W'(1))) state_nx = ST_TAIL;
            ST_TAIL:  if (fall) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q     <= '0;
            cnt_q    <= '0;
            remain_q <= '0;
            io_oe    <= 1'b0;
            cs_n     <= 1'b1;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (start_len == '0) begin
                            done <= 1'b1;
                        end else begin
                            sr_q     <= {RD_OPCODE, start_addr};
                            cnt_q    <= '0;
                            remain_q <= start_len;
                            io_oe    <= 1'b1;
                            cs_n     <= 1'b0;
                        end
                    end
                end
                ST_SEND: begin
                    if (rise) begin
                        cnt_q <= cnt_q + 1'b1;
                    end else if (fall) begin
                        if (cnt_q == CNT_W'(HDR_BITS)) begin
                            io_oe <= 1'b0;
                            cnt_q <= '0;
                        end else begin
                            sr_q <= {sr_q[HDR_BITS-2:0], 1'b0};
                        end
                    end
                end
                ST_DUMMY: begin
                    if (rise) begin
                        cnt_q <= cnt_q + 1'b1;
                    end else if (fall && (cnt_q == CNT_W'(DUMMY_CLKS))) begin
                        cnt_q <= '0;
                    end
                end
                ST_DATA: begin
                    if (rise) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (last_pair) remain_q <= remain_q - 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (fall) begin
                        cs_n <= 1'b1;
                        done <= 1'b1;
                    end
                end
                default: cs_n <= 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/rd_engine_chk.sv
module rd_engine_chk
    import spi_dual_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_n,
    input logic      sck,
    input logic      busy,
    input logic      done,
    input logic      m_valid,
    input logic      m_ready,
    input logic [7:0] m_data,
    input rd_state_e state,
    input logic      io_oe
);
    assert_cs_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    assert_sck_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    assert_line_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DUMMY || state == ST_DATA || state == ST_TAIL) |-> !io_oe);

    assert_stream_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !busy));
endmodule

bind dual_read_engine rd_engine_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .sck    (sck),
    .busy   (busy),
    .done   (done),
    .m_valid(m_valid),
    .m_ready(m_ready),
    .m_data (m_data),
    .state  (state),
    .io_oe  (io_oe)
);

// File: tb/tb_dual_read_engine.sv
module tb_dual_read_engine;
    localparam int HALF  = 2;
    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [23:0]      st_addr = '0;
    logic [LEN_W-1:0] st_len = '0;
    logic             busy, done, sck, cs_n;
    wire              io0;
    logic             io1 = 1'b0;
    logic [7:0]       m_data;
    logic             m_valid;
    logic             m_ready = 1'b0;

    int checks = 0;
    int errs   = 0;

    always #2 clk = ~clk;

    dual_read_engine #(.HALF(HALF), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(st_addr),
        .start_len(st_len), .busy(busy), .done(done), .sck(sck), .cs_n(cs_n),
        .io0(io0), .io1(io1), .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready)
    );

    function automatic logic [7:0] pat(input logic [23:0] a);
        return 8'((int'(a) * 13 + 7) & 255);
    endfunction

    // flash model: samples on rising sck, drives after falling sck
    int          fbits = 0;
    logic [31:0] frx = '0;
    logic        fdrv = 1'b0;
    logic        fd0 = 1'b0;
    assign io0 = fdrv ? fd0 : 1'bz;

    always @(negedge cs_n) fbits = 0;
    always @(posedge cs_n) begin #1 fdrv = 1'b0; end
    always @(posedge sck) if (!cs_n) begin
        if (fbits < 32) frx = {frx[30:0], io0};
        fbits = fbits + 1;
    end
    always @(negedge sck) if (!cs_n && fbits >= 40) begin
        int p;
        int k;
        logic [7:0] b;
        p = fbits - 40;
        k = p % 4;
        b = pat(frx[23:0] + 24'(p / 4));
        fdrv = 1'b1;
        io1  = b[7 - 2 * k];
        fd0  = b[6 - 2 * k];
    end

    // rising-edge gap monitor (R10)
    int   cyc_now = 0;
    int   nrise = 0;
    int   t_first = 0;
    int   gap12 = 0;
    logic sck_prev = 1'b0;
    always @(negedge clk) begin
        cyc_now = cyc_now + 1;
        if (cs_n) nrise = 0;
        else if (sck && !sck_prev) begin
            nrise = nrise + 1;
            if (nrise == 1) t_first = cyc_now;
            if (nrise == 2) gap12 = cyc_now - t_first;
        end
        sck_prev = sck;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // mode: 0 always ready, 1 alternate, 2 sparse, 3 long stall then ready
    task automatic run_xfer(input logic [23:0] addr, input int len, input int mode, input bit inject);
        int got = 0;
        int done_n = 0;
        int cyc = 0;
        @(negedge clk);
        start = 1'b1; st_addr = addr; st_len = LEN_W'(len);
        @(negedge clk);
        start = 1'b0;
        while (!(done_n > 0 && got == len) && cyc < 20000) begin
            logic r;
            if (mode == 0)      r = 1'b1;
            else if (mode == 1) r = cyc[0];
            else if (mode == 2) r = (cyc % 7 == 0);
            else                r = (cyc >= 300);
            if (mode == 3 && cyc == 299) begin
                chk(!sck && !cs_n && m_valid, "R6 stall keeps sck low, cs low, byte held",
                    {29'b0, sck, cs_n, m_valid}, 3'b001);
            end
            if (inject && cyc == 20) begin
                start = 1'b1; st_addr = ~addr; st_len = LEN_W'(len + 3);
            end else begin
                start = 1'b0;
            end
            m_ready = r;
            if (m_valid && r) begin
                chk(m_data == pat(24'(addr + 24'(got))), "R5 data byte", m_data, pat(24'(addr + 24'(got))));
                got++;
            end
            if (done) done_n++;
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        m_ready = 1'b0;
        repeat (4) begin
            if (done) done_n++;
            @(negedge clk);
        end
        chk(got == len, "R7 byte count", got, len);
        chk(done_n == 1, "R7 single done pulse", done_n, 1);
        chk(cs_n && !busy && !sck, "R7 idle after done", {cs_n, busy, sck}, 3'b100);
        chk(frx == {8'h3B, addr}, "R2 opcode and address", frx, {8'h3B, addr});
        chk(fbits == 40 + 4 * len, "R3 dummy clocks and total clocks", fbits, 40 + 4 * len);
        if (mode == 0) chk(gap12 == 2 * HALF, "R10 sck period", gap12, 2 * HALF);
        if (inject) chk(!m_valid, "R8 no extra transfer after ignored start", m_valid, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin : main
        logic [23:0] addrs [3];
        addrs[0] = 24'h000000;
        addrs[1] = 24'h5A3C81;
        addrs[2] = 24'hFFFFFE;
        repeat (5) @(negedge clk);
        chk(cs_n && !sck && !busy && !done && !m_valid, "R1 reset state",
            {cs_n, sck, busy, done, m_valid}, 5'b10000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n && !sck && !busy && !done && !m_valid, "R1 state after reset release",
            {cs_n, sck, busy, done, m_valid}, 5'b10000);

        // R9: zero-length request
        start = 1'b1; st_addr = 24'h123456; st_len = '0;
        @(negedge clk);
        start = 1'b0;
        chk(done && cs_n && !busy, "R9 zero length done", {done, cs_n, busy}, 3'b110);
        @(negedge clk);
        chk(!done && cs_n, "R9 done lasts one cycle", {done, cs_n}, 2'b01);

        for (int a = 0; a < 3; a++)
            for (int len = 1; len <= 5; len++)
                for (int m = 0; m < 3; m++)
                    run_xfer(addrs[a], len, m, 1'b0);

        run_xfer(24'h00ABCD, 3, 3, 1'b0);
        run_xfer(24'h400000, 4, 0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule